// File: doc/BRIEF.md
# Interval Timer with Toggle Output

The block is an up-counting interval timer. While the run control input is high, the counter advances by one on every system-clock cycle in which the count-clock enable is high. A compare value D defines the period. When the counter equals D on a count tick, the counter returns to zero, a one-cycle interrupt pulse is raised and the timer output pin changes level. Each period therefore lasts D + 1 ticks.

The compare value is written through a simple write strobe and data port. A write goes into the active compare buffer at once, even while the counter runs. A new value below the present count is not matched on the current pass. The counter keeps counting to the all-ones value, wraps to zero with an overflow pulse, and matches the new value on the next pass. Stopping the timer before writing a smaller value avoids this. While stopped, the output pin rests at a software-chosen idle level.

Top module: `interval_timer`

## Requirements
- R1: After reset, count_o is 0, match_irq_o and ovf_o are 0, and the compare value is all ones. With no compare write, the first match occurs on the 65536th tick after enable.
- R2: The counter changes only on cycles where both run_i and tick_i are high. With run_i high and tick_i low it holds its value, and each qualifying tick adds one.
- R3: A tick on which count_o equals the compare value clears count_o to 0. In the following cycle match_irq_o is high for exactly one cycle. The spacing between matches is D + 1 ticks.
- R4: Each match inverts toggle_o.
- R5: One cycle after run_i goes low, count_o is 0 and toggle_o has returned to its idle level. No match or overflow occurs while run_i is low.
- R6: While run_i is low, toggle_o follows idle_lvl_i with one cycle of delay. The first match after enable drives the inverse of that level.
- R7: A compare write (cmp_we_i high, value on cmp_wdata_i) is used for comparison from the next cycle on, even while counting. A larger value written mid-count suppresses the match at the old value.
- R8: If the value written mid-count is below the present count, no match occurs on that pass. The counter reaches 16'hFFFF, wraps to 0, and then matches the new value.
- R9: On a tick taken at count 16'hFFFF, count_o becomes 0 and ovf_o is high for one cycle after that tick.
- R10: A compare value written while stopped sets the first period after enable to D + 1 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Count run control; low clears the counter |
| tick_i | input | 1 | Count-clock enable, one system cycle per count |
| idle_lvl_i | input | 1 | Level of toggle_o while stopped |
| cmp_we_i | input | 1 | Compare write strobe |
| cmp_wdata_i | input | 16 | Compare write value |
| match_irq_o | output | 1 | One-cycle pulse per compare match |
| toggle_o | output | 1 | Timer output pin, inverted on each match |
| ovf_o | output | 1 | One-cycle pulse when the counter wraps past all ones |
| count_o | output | 16 | Current counter value |

## Verification
The assertions assume that all inputs are synchronous to clk_i and stable around its rising edge. They also assume that run_i alone decides whether a tick counts, so a tick with run_i low is harmless. The stimulus drives every input only just after a falling edge and holds write strobes for exactly one cycle. Compare writes are placed on cycles away from a match tick, so the write never meets a same-edge match.

// File: rtl/it_pkg.sv
package it_pkg;
  localparam int unsigned CNT_W_DEF = 16;

  typedef struct packed {
    logic hit;   // compare match taken on this tick
    logic wrap;  // tick taken at all-ones count
  } it_evt_t;
endpackage

// File: rtl/it_cmp_buf.sv
module it_cmp_buf #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cmp_o
);
  localparam logic [W-1:0] RST_VAL = '1;

  logic [W-1:0] cmp_q;

  // direct load into the active buffer, no deferral to a match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cmp_q <= RST_VAL;
    else if (we_i) cmp_q <= wdata_i;
  end

  assign cmp_o = cmp_q;

  // R7
  cmp_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> cmp_o == $past(wdata_i));
endmodule

// File: rtl/it_counter.sv
module it_counter
  import it_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] cmp_i,
  output logic [W-1:0] cnt_o,
  output it_evt_t      evt_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         step;

  assign step       = run_i && tick_i;
  assign evt_o.hit  = step && (cnt_q == cmp_i);
  assign evt_o.wrap = step && (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)          cnt_d = '0;
    else if (evt_o.hit)  cnt_d = '0;
    else if (tick_i)     cnt_d = cnt_q + 1'b1;  // rolls over at all ones
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> cnt_o == $past(cnt_o));
  // R5
  cnt_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_o == '0);
  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !evt_o.hit) |=> cnt_o == $past(cnt_o) + 1'b1);
endmodule

// File: rtl/it_toggle.sv
module it_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic idle_lvl_i,
  input  logic hit_i,
  output logic pin_o
);
  logic pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pin_q <= 1'b0;
    else if (!run_i) pin_q <= idle_lvl_i;
    else if (hit_i)  pin_q <= ~pin_q;
  end

  assign pin_o = pin_q;

  // R4
  pin_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> pin_o != $past(pin_o));
  // R6
  pin_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> pin_o == $past(idle_lvl_i));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import it_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             idle_lvl_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output logic             match_irq_o,
  output logic             toggle_o,
  output logic             ovf_o,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cmp;
  it_evt_t          evt;
  logic             irq_q, ovf_q;

  it_cmp_buf #(.W(CNT_W)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cmp_we_i),
    .wdata_i (cmp_wdata_i),
    .cmp_o   (cmp)
  );

  it_counter #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .tick_i (tick_i),
    .cmp_i  (cmp),
    .cnt_o  (count_o),
    .evt_o  (evt)
  );

  it_toggle u_tgl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .idle_lvl_i (idle_lvl_i),
    .hit_i      (evt.hit),
    .pin_o      (toggle_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      irq_q <= evt.hit;
      ovf_q <= evt.wrap;
    end
  end

  assign match_irq_o = irq_q;
  assign ovf_o       = ovf_q;

  // R3
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_irq_o |-> count_o == '0);
  // R9
  ovf_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> count_o == '0);
  // R5
  stop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !match_irq_o && !ovf_o);
endmodule

// File: tb/interval_timer_test.sv
module interval_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  typedef struct {
    int    cyc;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic        tick_i = 1'b0;
  logic        idle_lvl_i = 1'b0;
  logic        cmp_we_i = 1'b0;
  logic [15:0] cmp_wdata_i = '0;
  logic        match_irq_o, toggle_o, ovf_o;
  logic [15:0] count_o;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t q_irq[$];
  exp_t q_ovf[$];

  interval_timer uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .run_i       (run_i),
    .tick_i      (tick_i),
    .idle_lvl_i  (idle_lvl_i),
    .cmp_we_i    (cmp_we_i),
    .cmp_wdata_i (cmp_wdata_i),
    .match_irq_o (match_irq_o),
    .toggle_o    (toggle_o),
    .ovf_o       (ovf_o),
    .count_o     (count_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push_irq(input int c, input string tag);
    exp_t e; e.cyc = c; e.tag = tag; q_irq.push_back(e);
  endtask

  task automatic push_ovf(input int c, input string tag);
    exp_t e; e.cyc = c; e.tag = tag; q_ovf.push_back(e);
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic write_cmp(input logic [15:0] v);
    cmp_wdata_i = v;
    cmp_we_i    = 1'b1;
    @(negedge clk);
    cmp_we_i    = 1'b0;
  endtask

  task automatic stop_timer();
    run_i  = 1'b0;
    tick_i = 1'b0;
    @(negedge clk);
  endtask

  // monitor: pop expected pulses as they appear
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (q_irq.size() > 0 && q_irq[0].cyc < cyc) begin
        check({q_irq[0].tag, " irq missing"}, 0, 1);
        void'(q_irq.pop_front());
      end
      if (match_irq_o) begin
        if (q_irq.size() == 0) check("R3 unexpected irq", cyc, -1);
        else begin
          check({q_irq[0].tag, " irq cycle"}, cyc, q_irq[0].cyc);
          void'(q_irq.pop_front());
        end
      end
      if (q_ovf.size() > 0 && q_ovf[0].cyc < cyc) begin
        check({q_ovf[0].tag, " ovf missing"}, 0, 1);
        void'(q_ovf.pop_front());
      end
      if (ovf_o) begin
        if (q_ovf.size() == 0) check("R9 unexpected ovf", cyc, -1);
        else begin
          check({q_ovf[0].tag, " ovf cycle"}, cyc, q_ovf[0].cyc);
          void'(q_ovf.pop_front());
        end
      end
    end
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", count_o, 0);
    check("R1 irq", match_irq_o, 0);
    check("R1 ovf", ovf_o, 0);
    check("R6 idle low", toggle_o, 0);

    // R1 default compare all ones; R9 wrap at same tick
    c = cyc; run_i = 1'b1; tick_i = 1'b1;
    push_irq(c + 65536, "R1");
    push_ovf(c + 65536, "R9");
    wait_until(c + 65537);
    check("R4 toggled", toggle_o, 1);
    check("R9 count after wrap", count_o, 1);
    stop_timer();
    check("R5 count cleared", count_o, 0);
    check("R5 toggle idle", toggle_o, 0);

    // R6 idle level follows while stopped; R10 write while stopped
    idle_lvl_i = 1'b1;
    @(negedge clk);
    check("R6 idle high", toggle_o, 1);
    write_cmp(16'd9);
    c = cyc; run_i = 1'b1; tick_i = 1'b1;
    push_irq(c + 10, "R10");
    push_irq(c + 20, "R3");
    push_irq(c + 30, "R3");
    wait_until(c + 10);
    check("R6 first toggle inverts idle", toggle_o, 0);
    check("R3 cleared at match", count_o, 0);
    wait_until(c + 31);
    check("R4 three toggles", toggle_o, 0);
    check("R3 restart count", count_o, 1);
    stop_timer();
    check("R5 toggle back to idle", toggle_o, 1);

    // R2 tick gating
    run_i = 1'b1; tick_i = 1'b0;
    repeat (5) @(negedge clk);
    check("R2 hold without tick", count_o, 0);
    for (int k = 0; k < 6; k++) begin
      tick_i = 1'b1; @(negedge clk);
      tick_i = 1'b0; @(negedge clk);
    end
    check("R2 gated ticks", count_o, 6);
    stop_timer();

    // R7 larger value mid-count moves the match
    write_cmp(16'd30);
    c = cyc; run_i = 1'b1; tick_i = 1'b1;
    wait_until(c + 10);
    write_cmp(16'd40);
    push_irq(c + 41, "R7");
    wait_until(c + 42);
    check("R7 count after late match", count_o, 1);
    stop_timer();

    // R8 smaller value mid-count: run to all ones, wrap, then match
    write_cmp(16'd100);
    c = cyc; run_i = 1'b1; tick_i = 1'b1;
    wait_until(c + 50);
    write_cmp(16'd20);
    push_ovf(c + 65536, "R8");
    push_irq(c + 65557, "R8");
    wait_until(c + 150);
    check("R8 counts past old value", count_o, 150);
    wait_until(c + 65558);
    check("R8 count after match", count_o, 1);
    stop_timer();

    repeat (2) @(negedge clk);
    check("R3 no pending irq", q_irq.size(), 0);
    check("R9 no pending ovf", q_ovf.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc >= WATCHDOG);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule